// File: doc/BRIEF.md
# Data Transfer Activity Tracker

This block keeps the host-side view of block data transfers for a card-style storage controller. It holds four status flags: read in progress, write in progress, a block waiting in the buffer for the host to read, and room in the buffer for the host to write a block. Its inputs are one-cycle event strobes from the command and data engines. Its outputs are the four flags and four single-cycle interrupt pulses: transfer complete, block gap event, read buffer ready and write buffer ready.

A transfer starts when the command engine reports the end bit of a read or write command. At that point the programmed block count is loaded into an internal counter. Each finished block decrements the counter. A read block is finished when the host drains it. A write block is finished when its CRC status arrives. The transfer ends after the last block. A stop-at-gap request halts the transfer at the end of the current block and leaves it paused. A later continue request resumes the paused transfer in the same direction with the blocks that remain.

Top module: `xfer_tracker`

## Requirements
- R1: After reset all four flags and all four interrupt outputs are 0.
- R2: When no transfer is active, a read command end strobe sets `rd_xfer_act_o` on the next clock edge and loads `blk_cnt_i` (which must be 1 or more) as the number of blocks to move.
- R3: While reading, each `rd_blk_drained_i` finishes one block. When the last programmed block is drained, `rd_xfer_act_o` falls and `xfer_done_irq_o` pulses in the same cycle.
- R4: When no transfer is active, a write command end strobe sets `wr_xfer_act_o`. Each `wr_crc_ok_i` finishes one block. On the CRC status of the last block, `wr_xfer_act_o` falls and `xfer_done_irq_o` pulses.
- R5: A `stop_gap_i` strobe during a transfer takes effect when the current block finishes, and never in the middle of a block. A halted read pulses `xfer_done_irq_o`. A halted write pulses `gap_evt_irq_o` and not `xfer_done_irq_o`. When the halting block is also the last block, the transfer ends normally as in R3 or R4. A stop strobe while idle is ignored.
- R6: While a transfer is paused by R5, `cont_req_i` restores the active flag of the same direction and the remaining block count is kept. In any other state `cont_req_i` is ignored.
- R7: `rd_blk_rx_i` sets `buf_rd_rdy_o` and `rd_blk_drained_i` clears it. When both arrive together the set wins. `buf_rd_irq_o` pulses exactly when the flag goes from 0 to 1.
- R8: `buf_room_i` sets `buf_wr_rdy_o` and `buf_full_i` clears it. When both arrive together the set wins. `buf_wr_irq_o` pulses exactly when the flag goes from 0 to 1.
- R9: A read or write command end strobe is ignored while a transfer is active. It changes neither the direction nor the remaining count.
- R10: Every interrupt output is high for one cycle at a time.
- R11: `rd_xfer_act_o` and `wr_xfer_act_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blk_cnt_i | input | CNT_W | Programmed number of blocks, sampled at command end |
| cmd_rd_end_i | input | 1 | End bit of a read command seen |
| cmd_wr_end_i | input | 1 | End bit of a write command seen |
| cont_req_i | input | 1 | Continue request, resumes a paused transfer |
| stop_gap_i | input | 1 | Stop-at-block-gap request |
| rd_blk_rx_i | input | 1 | A whole block has been received into the buffer |
| rd_blk_drained_i | input | 1 | Host has read the whole buffered block |
| wr_crc_ok_i | input | 1 | CRC status for a written block has been received |
| buf_room_i | input | 1 | Buffer has room for the start of a block |
| buf_full_i | input | 1 | Buffer has become full |
| rd_xfer_act_o | output | 1 | Read transfer in progress |
| wr_xfer_act_o | output | 1 | Write transfer in progress |
| buf_rd_rdy_o | output | 1 | Block available for the host to read |
| buf_wr_rdy_o | output | 1 | Space available for the host to write |
| xfer_done_irq_o | output | 1 | Transfer complete pulse |
| gap_evt_irq_o | output | 1 | Block gap event pulse |
| buf_rd_irq_o | output | 1 | Read buffer ready pulse |
| buf_wr_irq_o | output | 1 | Write buffer ready pulse |

## Verification
A wrong block counter shows up at the transfer's last block. The active flag falls one block early or one block late, together with a missing or misplaced completion pulse, so every block count in the sweep exposes it within that transfer. A stop request that is latched wrongly, or a pause state that is lost, shows up at the first block boundary after the stop. The symptoms are the wrong interrupt kind, or a continue request that fails to restore the flag one cycle later. Faults in the ready flags show up one cycle after the offending strobe pair as a wrong flag level or a wrong pulse.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } xfer_dir_e;

  localparam int unsigned DEF_CNT_W = 16;
endpackage

// File: rtl/xfer_blk_counter.sv
module xfer_blk_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (dec_i && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // a zero count is treated as a single block
  assign last_o = (cnt_q <= ONE);
endmodule

// File: rtl/xfer_ready_flag.sv
module xfer_ready_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, flag_d, irq_q;

  assign flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & ~flag_q;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/xfer_act_ctrl.sv
module xfer_act_ctrl
  import xfer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_rd_i,
  input  logic cmd_wr_i,
  input  logic cont_i,
  input  logic stop_i,
  input  logic rd_blk_i,
  input  logic wr_blk_i,
  input  logic last_i,
  output logic load_o,
  output logic dec_o,
  output logic rd_act_o,
  output logic wr_act_o,
  output logic done_irq_o,
  output logic gap_irq_o
);
  logic      rd_q, wr_q, stop_q, paused_q, done_q, gap_q;
  xfer_dir_e dir_q;

  logic idle, start_rd, start_wr, resume, stop_eff;
  logic rd_fin, wr_fin, blk_fin, ends, halts;

  assign idle     = ~rd_q & ~wr_q;
  assign start_rd = idle & cmd_rd_i;
  assign start_wr = idle & cmd_wr_i & ~cmd_rd_i;
  assign resume   = paused_q & cont_i & ~start_rd & ~start_wr;
  assign stop_eff = stop_q | stop_i;

  assign rd_fin  = rd_q & rd_blk_i;
  assign wr_fin  = wr_q & wr_blk_i;
  assign blk_fin = rd_fin | wr_fin;
  assign ends    = blk_fin & last_i;
  assign halts   = blk_fin & ~last_i & stop_eff;

  assign load_o = start_rd | start_wr;
  assign dec_o  = blk_fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      stop_q   <= 1'b0;
      paused_q <= 1'b0;
      done_q   <= 1'b0;
      gap_q    <= 1'b0;
      dir_q    <= DIR_RD;
    end else begin
      done_q <= (rd_fin & (last_i | stop_eff)) | (wr_fin & last_i);
      gap_q  <= wr_fin & ~last_i & stop_eff;

      if (start_rd || (resume && dir_q == DIR_RD)) begin
        rd_q <= 1'b1;
      end else if (rd_fin && (last_i || stop_eff)) begin
        rd_q <= 1'b0;
      end

      if (start_wr || (resume && dir_q == DIR_WR)) begin
        wr_q <= 1'b1;
      end else if (wr_fin && (last_i || stop_eff)) begin
        wr_q <= 1'b0;
      end

      if (start_rd) begin
        dir_q <= DIR_RD;
      end else if (start_wr) begin
        dir_q <= DIR_WR;
      end

      if (start_rd || start_wr || resume) begin
        paused_q <= 1'b0;
      end else if (halts) begin
        paused_q <= 1'b1;
      end

      // stop waits for the current block boundary
      if (ends || halts || start_rd || start_wr) begin
        stop_q <= 1'b0;
      end else if (stop_i && !idle) begin
        stop_q <= 1'b1;
      end
    end
  end

  assign rd_act_o   = rd_q;
  assign wr_act_o   = wr_q;
  assign done_irq_o = done_q;
  assign gap_irq_o  = gap_q;
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
  parameter int unsigned CNT_W = xfer_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] blk_cnt_i,
  input  logic             cmd_rd_end_i,
  input  logic             cmd_wr_end_i,
  input  logic             cont_req_i,
  input  logic             stop_gap_i,
  input  logic             rd_blk_rx_i,
  input  logic             rd_blk_drained_i,
  input  logic             wr_crc_ok_i,
  input  logic             buf_room_i,
  input  logic             buf_full_i,
  output logic             rd_xfer_act_o,
  output logic             wr_xfer_act_o,
  output logic             buf_rd_rdy_o,
  output logic             buf_wr_rdy_o,
  output logic             xfer_done_irq_o,
  output logic             gap_evt_irq_o,
  output logic             buf_rd_irq_o,
  output logic             buf_wr_irq_o
);
  localparam int unsigned N_FLAGS = 2;

  logic load, dec, last;
  logic [N_FLAGS-1:0] f_set, f_clr, f_val, f_irq;

  xfer_act_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_rd_i   (cmd_rd_end_i),
    .cmd_wr_i   (cmd_wr_end_i),
    .cont_i     (cont_req_i),
    .stop_i     (stop_gap_i),
    .rd_blk_i   (rd_blk_drained_i),
    .wr_blk_i   (wr_crc_ok_i),
    .last_i     (last),
    .load_o     (load),
    .dec_o      (dec),
    .rd_act_o   (rd_xfer_act_o),
    .wr_act_o   (wr_xfer_act_o),
    .done_irq_o (xfer_done_irq_o),
    .gap_irq_o  (gap_evt_irq_o)
  );

  xfer_blk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (blk_cnt_i),
    .dec_i  (dec),
    .last_o (last)
  );

  // index 0: read side of the buffer, index 1: write side
  assign f_set = {buf_room_i, rd_blk_rx_i};
  assign f_clr = {buf_full_i, rd_blk_drained_i};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    xfer_ready_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .flag_o (f_val[g]),
      .irq_o  (f_irq[g])
    );
  end

  assign buf_rd_rdy_o = f_val[0];
  assign buf_wr_rdy_o = f_val[1];
  assign buf_rd_irq_o = f_irq[0];
  assign buf_wr_irq_o = f_irq[1];
endmodule

// File: rtl/xfer_tracker_chk.sv
module xfer_tracker_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_rd_end_i,
  input logic cmd_wr_end_i,
  input logic cont_req_i,
  input logic rd_xfer_act_o,
  input logic wr_xfer_act_o,
  input logic buf_rd_rdy_o,
  input logic buf_wr_rdy_o,
  input logic xfer_done_irq_o,
  input logic gap_evt_irq_o,
  input logic buf_rd_irq_o,
  input logic buf_wr_irq_o
);
  a_r2_rd_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_xfer_act_o) |-> $past(cmd_rd_end_i | cont_req_i));

  a_r4_wr_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_xfer_act_o) |-> $past(cmd_wr_end_i | cont_req_i));

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_xfer_act_o && wr_xfer_act_o));

  a_r3_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_irq_o |-> ($fell(rd_xfer_act_o) || $fell(wr_xfer_act_o)));

  a_r5_gap_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_evt_irq_o |-> ($fell(wr_xfer_act_o) && !xfer_done_irq_o));

  a_r7_rd_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_irq_o |-> $rose(buf_rd_rdy_o));

  a_r8_wr_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_irq_o |-> $rose(buf_wr_rdy_o));

  a_r10_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_irq_o || gap_evt_irq_o) |=> !(xfer_done_irq_o || gap_evt_irq_o));
endmodule

bind xfer_tracker xfer_tracker_chk chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_rd_end_i    (cmd_rd_end_i),
  .cmd_wr_end_i    (cmd_wr_end_i),
  .cont_req_i      (cont_req_i),
  .rd_xfer_act_o   (rd_xfer_act_o),
  .wr_xfer_act_o   (wr_xfer_act_o),
  .buf_rd_rdy_o    (buf_rd_rdy_o),
  .buf_wr_rdy_o    (buf_wr_rdy_o),
  .xfer_done_irq_o (xfer_done_irq_o),
  .gap_evt_irq_o   (gap_evt_irq_o),
  .buf_rd_irq_o    (buf_rd_irq_o),
  .buf_wr_irq_o    (buf_wr_irq_o)
);

// File: tb/xfer_tracker_tb_top.sv
`timescale 1ns/1ps
module xfer_tracker_tb_top;
  localparam int CNT_W = 4;
  localparam int S_CRD = 0, S_CWR = 1, S_CONT = 2, S_STOP = 3, S_RX = 4;
  localparam int S_DRN = 5, S_CRC = 6, S_ROOM = 7, S_FULL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] stim = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic rd_act, wr_act, brr, bwr, done, gap, brirq, bwirq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xfer_tracker #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .blk_cnt_i(cnt),
    .cmd_rd_end_i(stim[S_CRD]), .cmd_wr_end_i(stim[S_CWR]),
    .cont_req_i(stim[S_CONT]), .stop_gap_i(stim[S_STOP]),
    .rd_blk_rx_i(stim[S_RX]), .rd_blk_drained_i(stim[S_DRN]),
    .wr_crc_ok_i(stim[S_CRC]), .buf_room_i(stim[S_ROOM]),
    .buf_full_i(stim[S_FULL]),
    .rd_xfer_act_o(rd_act), .wr_xfer_act_o(wr_act),
    .buf_rd_rdy_o(brr), .buf_wr_rdy_o(bwr),
    .xfer_done_irq_o(done), .gap_evt_irq_o(gap),
    .buf_rd_irq_o(brirq), .buf_wr_irq_o(bwirq)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  // one strobe cycle, outputs sampled at the following falling edge
  task automatic cyc(input logic [8:0] s);
    stim = s;
    @(negedge clk);
    stim = '0;
  endtask

  function automatic logic [8:0] bit_of(input int i);
    return 9'(1) << i;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd_act", rd_act, 1'b0); chk("R1 wr_act", wr_act, 1'b0);
    chk("R1 brr", brr, 1'b0);       chk("R1 bwr", bwr, 1'b0);
    chk("R1 done", done, 1'b0);     chk("R1 gap", gap, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", rd_act | wr_act | brr | bwr | done | gap | brirq | bwirq, 1'b0);

    // read sweep: block count n, stop during block s (0 = none)
    for (int n = 1; n <= 4; n++) begin
      for (int s = 0; s <= n; s++) begin
        cnt = CNT_W'(n);
        cyc(bit_of(S_CRD));
        chk("R2 rd set", rd_act, 1'b1);
        chk("R11 wr idle", wr_act, 1'b0);
        for (int b = 1; b <= n; b++) begin
          cyc(bit_of(S_RX));
          chk("R7 brr set", brr, 1'b1); chk("R7 brirq", brirq, 1'b1);
          if (b == s) begin
            cyc(bit_of(S_STOP));
            chk("R5 mid-block keeps rd", rd_act, 1'b1);
          end
          cyc(bit_of(S_DRN));
          chk("R3 rd level", rd_act, !((b == n) || (b == s)));
          chk("R3 done pulse", done, (b == n) || (b == s));
          chk("R5 no gap on read", gap, 1'b0);
          chk("R7 brr clear", brr, 1'b0);
          cyc('0);
          chk("R10 done single", done, 1'b0);
          if (b == s && b < n) begin
            cyc(bit_of(S_CONT));
            chk("R6 resume read", rd_act, 1'b1);
            chk("R6 no write", wr_act, 1'b0);
          end
        end
        cyc(bit_of(S_CONT));
        chk("R6 cont ignored", rd_act | wr_act, 1'b0);
      end
    end

    // write sweep
    for (int n = 1; n <= 4; n++) begin
      for (int s = 0; s <= n; s++) begin
        cnt = CNT_W'(n);
        cyc(bit_of(S_CWR));
        chk("R4 wr set", wr_act, 1'b1);
        chk("R11 rd idle", rd_act, 1'b0);
        for (int b = 1; b <= n; b++) begin
          if (b == s) begin
            cyc(bit_of(S_STOP));
            chk("R5 mid-block keeps wr", wr_act, 1'b1);
          end
          cyc(bit_of(S_CRC));
          chk("R4 wr level", wr_act, !((b == n) || (b == s)));
          chk("R4 done pulse", done, b == n);
          chk("R5 gap pulse", gap, (b == s) && (b < n));
          cyc('0);
          chk("R10 gap single", gap | done, 1'b0);
          if (b == s && b < n) begin
            cyc(bit_of(S_CONT));
            chk("R6 resume write", wr_act, 1'b1);
          end
        end
        cyc(bit_of(S_CONT));
        chk("R6 cont ignored w", rd_act | wr_act, 1'b0);
      end
    end

    // command while active is ignored; count stays
    cnt = CNT_W'(2);
    cyc(bit_of(S_CRD));
    cnt = CNT_W'(5);
    cyc(bit_of(S_CWR));
    chk("R9 wr ignored", wr_act, 1'b0);
    cyc(bit_of(S_CRD));
    cyc(bit_of(S_DRN));
    chk("R9 still reading", rd_act, 1'b1);
    cyc(bit_of(S_DRN));
    chk("R9 ends at 2", rd_act, 1'b0);
    chk("R9 done", done, 1'b1);

    // stop while idle is ignored
    cyc(bit_of(S_STOP));
    cnt = CNT_W'(2);
    cyc(bit_of(S_CWR));
    cyc(bit_of(S_CRC));
    chk("R5 idle stop ignored", wr_act, 1'b1);
    chk("R5 idle stop no gap", gap, 1'b0);
    cyc(bit_of(S_CRC));
    chk("R4 end", wr_act, 1'b0);
    cyc(bit_of(S_DRN));
    chk("R3 idle drain", rd_act | done, 1'b0);

    // ready flags: all set/clear pairs from both starting levels
    for (int init = 0; init < 2; init++) begin
      for (int c = 0; c < 4; c++) begin
        logic sset, sclr, e;
        sset = c[0]; sclr = c[1];
        e = sset | (init[0] & ~sclr);
        cyc(init[0] ? bit_of(S_RX) : bit_of(S_DRN));
        cyc(init[0] ? bit_of(S_ROOM) : bit_of(S_FULL));
        cyc('0);
        cyc((sset ? bit_of(S_RX) : 9'd0) | (sclr ? bit_of(S_DRN) : 9'd0));
        chk("R7 flag", brr, e);
        chk("R7 irq", brirq, e & ~init[0]);
        cyc((sset ? bit_of(S_ROOM) : 9'd0) | (sclr ? bit_of(S_FULL) : 9'd0));
        chk("R8 flag", bwr, e);
        chk("R8 irq", bwirq, e & ~init[0]);
        cyc('0);
        chk("R10 irq single", brirq | bwirq, 1'b0);
      end
    end

    finish_run();
  end
endmodule